// File: doc/BRIEF.md
# Prefix and Conditional-Skip Instruction Sequencer

This block sits after instruction fetch and walks the fetched words strictly in order. Two kinds of words only modify what follows them. A prefix word adds a slice of immediate bits to an accumulator. A condition word compares two operands, and when the comparison is false it cancels the next real instruction. Every other word is a real instruction. For each real instruction the block reports the word itself, the full-width immediate built from any prefixes ahead of it, whether the instruction executes or is cancelled, and how many fetched words the program counter moves past for it.

Prefixes belong to the word that comes after them, so a cancelled instruction loses its prefixes too. Condition words may be stacked in front of one real instruction. That instruction executes only if every condition in the stack holds. Once one condition has failed, the prefix and condition words that follow it up to the next real instruction are absorbed without effect. A prefix may also widen the immediate operand of a condition word.

Top module: `pfx_cond_seq`

## Requirements
- R1: After reset no output is valid, the skip state is clear and the accumulator is empty. The first real instruction then executes, and its immediate is its short immediate zero-extended.
- R2: Words are classified by bits [31:28]. The value 4'hF marks a prefix and 4'hE marks a condition. Any other value is a real instruction. Prefix and condition words never produce an output.
- R3: A prefix not under a pending skip shifts the accumulator left by PFX_W bits and places its payload, bits [PFX_W-1:0], in the low end. A real instruction's immediate is the low DW bits of {accumulator, word[SIMM_W-1:0]}.
- R4: The accumulator is emptied when a real instruction or an evaluated condition word consumes it, so the next word starts from zero.
- R5: A condition word holds a relation code in [27:25] (0 EQ, 1 NE, 2 signed LT, 3 signed GE, 4 signed GT, 5 signed LE, 6 unsigned LT, 7 unsigned GE) and an operand select in [24]. It compares cond_a against cond_b when [24]=0, or against its assembled immediate when [24]=1.
- R6: A failing condition makes the next real instruction appear with out_exec=0.
- R7: While a skip is pending, prefix words are not accumulated and condition words are not evaluated. The skip ends after exactly one real instruction has been cancelled.
- R8: With stacked conditions, the real instruction executes only if all of them hold. A failure in the first, a middle or the last position cancels it.
- R9: out_valid pulses for one cycle, one clock after each accepted real word, with out_word equal to that word.
- R10: out_step counts the accepted words since the previous real instruction, this one included, and saturates at 2^STEP_W-1.
- R11: Cycles with in_valid low change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetched word is presented this cycle |
| in_word | input | DW | Fetched instruction word |
| cond_a | input | DW | First comparison operand, used with a condition word |
| cond_b | input | DW | Second register operand, used with a condition word |
| out_valid | output | 1 | A real instruction is reported |
| out_word | output | DW | The real instruction word |
| out_imm | output | DW | Assembled immediate |
| out_exec | output | 1 | 1 = execute, 0 = cancelled |
| out_step | output | STEP_W | Words advanced for this instruction |

## Verification
The bench uses the defaults: DW=32, PFX_W=12, SIMM_W=8 and STEP_W=4. With these widths, three prefixes already run past 32 bits, so truncation of the high bits is exercised. The narrow step counter reaches saturation after a run of seventeen words. The scoreboard model rebuilds the immediates with 64-bit arithmetic. It runs stacks of three conditions that fail in each position, condition immediates widened by a prefix, and signed against unsigned relations on the same operands.

// File: rtl/pfxseq_pkg.sv
package pfxseq_pkg;

  typedef enum logic [1:0] {
    WK_REAL   = 2'd0,
    WK_PREFIX = 2'd1,
    WK_COND   = 2'd2
  } word_kind_e;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_LT  = 3'd2,
    REL_GE  = 3'd3,
    REL_GT  = 3'd4,
    REL_LE  = 3'd5,
    REL_LTU = 3'd6,
    REL_GEU = 3'd7
  } rel_e;

  localparam logic [3:0] OPC_PREFIX = 4'hF;
  localparam logic [3:0] OPC_COND   = 4'hE;

  function automatic word_kind_e classify(input logic [3:0] opc);
    if (opc == OPC_PREFIX)    return WK_PREFIX;
    else if (opc == OPC_COND) return WK_COND;
    else                      return WK_REAL;
  endfunction

endpackage

// File: rtl/pfx_accum.sv
module pfx_accum #(
  parameter int DW     = 32,
  parameter int PFX_W  = 12,
  parameter int SIMM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              consume,
  input  logic              skip_i,
  input  logic [PFX_W-1:0]  payload,
  input  logic [SIMM_W-1:0] simm,
  output logic [DW-1:0]     acc_o,
  output logic [DW-1:0]     imm_o
);
  localparam int WIDE_A = DW + SIMM_W;
  localparam int WIDE_P = DW + PFX_W;

  function automatic logic [DW-1:0] push_slice(input logic [DW-1:0] acc,
                                                input logic [PFX_W-1:0] p);
    logic [WIDE_P-1:0] wide;
    wide = {acc, p};
    return wide[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] assemble(input logic [DW-1:0] acc,
                                              input logic [SIMM_W-1:0] s);
    logic [WIDE_A-1:0] wide;
    wide = {acc, s};
    return wide[DW-1:0];
  endfunction

  logic [DW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (shift_en) acc_q <= push_slice(acc_q, payload);
    else if (consume)  acc_q <= '0;
  end

  assign acc_o = acc_q;
  assign imm_o = assemble(acc_q, simm);

  assert_slice_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> acc_q[PFX_W-1:0] == $past(payload));

  assert_cleared_after_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !shift_en) |=> acc_q == '0);

  assert_empty_while_skipping_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_i |-> acc_q == '0);
endmodule

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int DW = 32
) (
  input  pfxseq_pkg::rel_e rel,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  output logic             pass
);
  import pfxseq_pkg::*;

  function automatic logic rel_holds(input rel_e r, input logic [DW-1:0] a,
                                     input logic [DW-1:0] b);
    logic slt, ult;
    slt = $signed(a) < $signed(b);
    ult = a < b;
    case (r)
      REL_EQ:  return a == b;
      REL_NE:  return a != b;
      REL_LT:  return slt;
      REL_GE:  return !slt;
      REL_GT:  return !slt && (a != b);
      REL_LE:  return slt || (a == b);
      REL_LTU: return ult;
      default: return !ult;
    endcase
  endfunction

  assign pass = rel_holds(rel, opa, opb);

  always_comb begin
    if (rel == REL_EQ) assert_eq_exact_R5: assert (pass == (opa == opb));
  end
endmodule

// File: rtl/skip_track.sv
module skip_track #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_fire,
  input  logic              is_real,
  input  logic              is_cond,
  input  logic              cond_pass,
  output logic              skip_q,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] STEP_MAX = '1;

  function automatic logic [STEP_W-1:0] sat_inc(input logic [STEP_W-1:0] c);
    return (c == STEP_MAX) ? c : c + 1'b1;
  endfunction

  logic [STEP_W-1:0] cnt_q;
  logic              fail_event;

  assign fail_event = word_fire && is_cond && !skip_q && !cond_pass;
  assign step_o     = sat_inc(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      cnt_q  <= '0;
    end else if (word_fire) begin
      if (is_real) begin
        skip_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= sat_inc(cnt_q);
        if (fail_event) skip_q <= 1'b1;
      end
    end
  end

  assert_fail_arms_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_event |=> skip_q);

  assert_one_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && is_real) |=> !skip_q);

  assert_step_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_o != '0);
endmodule

// File: rtl/pfx_cond_seq.sv
module pfx_cond_seq #(
  parameter int DW     = 32,
  parameter int PFX_W  = 12,
  parameter int SIMM_W = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_word,
  input  logic [DW-1:0]     cond_a,
  input  logic [DW-1:0]     cond_b,
  output logic              out_valid,
  output logic [DW-1:0]     out_word,
  output logic [DW-1:0]     out_imm,
  output logic              out_exec,
  output logic [STEP_W-1:0] out_step
);
  import pfxseq_pkg::*;

  localparam int OPC_LSB = DW - 4;
  localparam int REL_LSB = DW - 7;
  localparam int SEL_BIT = DW - 8;

  word_kind_e        kind;
  logic              skip_q;
  logic              real_fire, pfx_fire, cond_fire, consume;
  logic              cond_pass, imm_sel;
  rel_e              rel;
  logic [DW-1:0]     acc, imm, opb;
  logic [STEP_W-1:0] step;

  assign kind      = classify(in_word[DW-1:OPC_LSB]);
  assign real_fire = in_valid && (kind == WK_REAL);
  assign pfx_fire  = in_valid && (kind == WK_PREFIX) && !skip_q;
  assign cond_fire = in_valid && (kind == WK_COND) && !skip_q;
  assign consume   = real_fire || cond_fire;
  assign rel       = rel_e'(in_word[REL_LSB+2:REL_LSB]);
  assign imm_sel   = in_word[SEL_BIT];
  assign opb       = imm_sel ? imm : cond_b;

  pfx_accum #(.DW(DW), .PFX_W(PFX_W), .SIMM_W(SIMM_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(pfx_fire),
    .consume (consume),
    .skip_i  (skip_q),
    .payload (in_word[PFX_W-1:0]),
    .simm    (in_word[SIMM_W-1:0]),
    .acc_o   (acc),
    .imm_o   (imm)
  );

  cond_eval #(.DW(DW)) u_cond (
    .rel (rel),
    .opa (cond_a),
    .opb (opb),
    .pass(cond_pass)
  );

  skip_track #(.STEP_W(STEP_W)) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_fire(in_valid),
    .is_real  (kind == WK_REAL),
    .is_cond  (kind == WK_COND),
    .cond_pass(cond_pass),
    .skip_q   (skip_q),
    .step_o   (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_imm   <= '0;
      out_exec  <= 1'b0;
      out_step  <= '0;
    end else begin
      out_valid <= real_fire;
      if (real_fire) begin
        out_word <= in_word;
        out_imm  <= imm;
        out_exec <= !skip_q;
        out_step <= step;
      end
    end
  end

  assert_pulse_follows_real_R9: assert property (@(posedge clk) disable iff (!rst_n)
    real_fire |=> out_valid && out_word == $past(in_word));

  assert_modifier_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind != WK_REAL) |=> !out_valid);

  assert_skip_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (real_fire && skip_q) |=> out_valid && !out_exec);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(skip_q) && $stable(acc));
endmodule

// File: tb/tb_pfx_cond_seq.sv
module tb_pfx_cond_seq;
  localparam int DW = 32;
  localparam int STEP_MAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_word = '0, cond_a = '0, cond_b = '0;
  logic          out_valid, out_exec;
  logic [DW-1:0] out_word, out_imm;
  logic [3:0]    out_step;

  always #5 clk = ~clk;

  pfx_cond_seq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .cond_a(cond_a), .cond_b(cond_b), .out_valid(out_valid), .out_word(out_word),
    .out_imm(out_imm), .out_exec(out_exec), .out_step(out_step)
  );

  typedef struct {
    logic [31:0] word;
    logic [31:0] imm;
    logic        exec;
    int          step;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;

  logic [63:0] m_acc = 0;
  logic        m_skip = 0;
  int          m_cnt = 0;

  function automatic logic [31:0] mk_real(input logic [7:0] op, input logic [7:0] s);
    return {4'h2, op, 12'h0, s};
  endfunction
  function automatic logic [31:0] mk_pfx(input logic [11:0] p);
    return {4'hF, 16'h0, p};
  endfunction
  function automatic logic [31:0] mk_cond(input logic [2:0] r, input logic sel,
                                           input logic [7:0] s);
    return {4'hE, r, sel, 16'h0, s};
  endfunction

  function automatic logic holds(input logic [2:0] r, input logic [31:0] a,
                                 input logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (r)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return sa < sb;
      3'd3: return sa >= sb;
      3'd4: return sa > sb;
      3'd5: return sa <= sb;
      3'd6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic put(input logic [31:0] w, input logic [31:0] a,
                     input logic [31:0] b, input string tag);
    logic [31:0] ci;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    cond_a   = a;
    cond_b   = b;
    m_cnt++;
    if (w[31:28] == 4'hF) begin
      if (!m_skip) m_acc = ((m_acc << 12) | 64'(w[11:0])) & 64'hFFFF_FFFF;
    end else if (w[31:28] == 4'hE) begin
      if (!m_skip) begin
        ci = 32'((m_acc << 8) | 64'(w[7:0]));
        if (!holds(w[27:25], a, w[24] ? ci : b)) m_skip = 1'b1;
        m_acc = 0;
      end
    end else begin
      e.word = w;
      e.imm  = 32'((m_acc << 8) | 64'(w[7:0]));
      e.exec = !m_skip;
      e.step = (m_cnt > STEP_MAX) ? STEP_MAX : m_cnt;
      e.tag  = tag;
      exp_q.push_back(e);
      m_acc = 0; m_skip = 1'b0; m_cnt = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 32'hFFFF_FFFF;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compare each reported instruction against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", $sformatf("unexpected output word %h, expected none", out_word));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_word == e.word && out_imm == e.imm && out_exec == e.exec &&
                int'(out_step) == e.step, e.tag,
                $sformatf("got word=%h imm=%h exec=%0d step=%0d expected word=%h imm=%h exec=%0d step=%0d",
                          out_word, out_imm, out_exec, out_step, e.word, e.imm, e.exec, e.step));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", $sformatf("out_valid=%0d during reset, expected 0", out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", $sformatf("out_valid=%0d after reset, expected 0", out_valid));

    // R1 first instruction, no prefix
    put(mk_real(8'h01, 8'hAB), 0, 0, "R1");
    // R3 prefix chains of length 1, 2 and 3 (3 truncates to 32 bits)
    put(mk_pfx(12'h123), 0, 0, "R3");
    put(mk_real(8'h02, 8'h45), 0, 0, "R3");
    put(mk_pfx(12'hABC), 0, 0, "R3");
    put(mk_pfx(12'hDEF), 0, 0, "R3");
    put(mk_real(8'h03, 8'h12), 0, 0, "R3");
    put(mk_pfx(12'h001), 0, 0, "R3");
    put(mk_pfx(12'h234), 0, 0, "R3");
    put(mk_pfx(12'h567), 0, 0, "R3");
    put(mk_real(8'h04, 8'h89), 0, 0, "R3");
    // R4 accumulator empty for following word
    put(mk_real(8'h05, 8'h66), 0, 0, "R4");
    // R5 register compare pass / fail
    put(mk_cond(3'd4, 1'b0, 8'h00), 32'd5, 32'd3, "R5");
    put(mk_real(8'h06, 8'h01), 0, 0, "R5");
    put(mk_cond(3'd4, 1'b0, 8'h00), 32'd3, 32'd3, "R6");
    put(mk_real(8'h07, 8'h02), 0, 0, "R6");
    // R5 immediate compare widened by a prefix, then R4 after condition
    put(mk_pfx(12'h001), 0, 0, "R5");
    put(mk_cond(3'd3, 1'b1, 8'h00), 32'h100, 0, "R5");
    put(mk_real(8'h08, 8'h03), 0, 0, "R4");
    put(mk_pfx(12'h001), 0, 0, "R5");
    put(mk_cond(3'd0, 1'b1, 8'h01), 32'h100, 0, "R5");
    put(mk_real(8'h09, 8'h04), 0, 0, "R5");
    // R5 signed vs unsigned on same operands
    put(mk_cond(3'd2, 1'b0, 0), 32'hFFFF_FFFF, 32'd1, "R5");
    put(mk_real(8'h0A, 8'h05), 0, 0, "R5");
    put(mk_cond(3'd6, 1'b0, 0), 32'hFFFF_FFFF, 32'd1, "R5");
    put(mk_real(8'h0B, 8'h06), 0, 0, "R5");
    put(mk_cond(3'd7, 1'b0, 0), 32'hFFFF_FFFF, 32'd1, "R5");
    put(mk_real(8'h0C, 8'h07), 0, 0, "R5");
    put(mk_cond(3'd5, 1'b0, 0), 32'd2, 32'd2, "R5");
    put(mk_real(8'h0D, 8'h08), 0, 0, "R5");
    put(mk_cond(3'd1, 1'b0, 0), 32'd2, 32'd2, "R5");
    put(mk_real(8'h0E, 8'h09), 0, 0, "R5");

    // R8 stacks of three: all pass, fail first, middle, last
    for (int f = 0; f < 4; f++) begin
      put(mk_cond(3'd3, 1'b0, 0), 32'd9, (f == 1) ? 32'd10 : 32'd1, "R8");
      put(mk_pfx(12'h0F0), 0, 0, "R8");
      put(mk_cond(3'd1, 1'b1, 8'h11), (f == 2) ? 32'h0F011 : 32'd7, 0, "R8");
      put(mk_cond(3'd2, 1'b0, 0), (f == 3) ? 32'd50 : 32'd1, 32'd20, "R8");
      put(mk_pfx(12'h777), 0, 0, "R7");
      put(mk_real(8'h10, 8'h5A), 0, 0, "R8");
      // R7 next instruction executes with a clean accumulator
      put(mk_real(8'h11, 8'h3C), 0, 0, "R7");
    end

    // R7 words under a pending skip: a failing condition does not extend it
    put(mk_cond(3'd0, 1'b0, 0), 32'd1, 32'd2, "R7");
    put(mk_cond(3'd0, 1'b0, 0), 32'd1, 32'd2, "R7");
    put(mk_pfx(12'hABC), 0, 0, "R7");
    put(mk_real(8'h12, 8'h01), 0, 0, "R7");
    put(mk_real(8'h13, 8'h02), 0, 0, "R7");

    // R11 idle gaps inside a prefix chain
    put(mk_pfx(12'h345), 0, 0, "R11");
    idle(3);
    put(mk_real(8'h14, 8'h67), 0, 0, "R11");
    idle(2);
    check(exp_q.size() == 0, "R9", $sformatf("%0d outputs pending, expected 0", exp_q.size()));

    // R10 step saturation after 16 prefixes
    for (int i = 0; i < 16; i++) put(mk_pfx(12'(i)), 0, 0, "R10");
    put(mk_real(8'h15, 8'h99), 0, 0, "R10");
    put(mk_pfx(12'h00A), 0, 0, "R10");
    put(mk_cond(3'd0, 1'b0, 0), 32'd4, 32'd4, "R10");
    put(mk_real(8'h16, 8'h98), 0, 0, "R10");
    idle(4);
    check(exp_q.size() == 0, "R9", $sformatf("%0d outputs pending, expected 0", exp_q.size()));
    summary();
    $finish;
  end
endmodule